// File: doc/BRIEF.md
# Channel Slot Timing and Strobe Generator

This block is the timing heart of a time-shared multichannel voice codec. One set of arithmetic serves many channels in turn, and each channel gets a fixed window of 32 active clock cycles, called a slot. The block counts the cycles inside the slot and counts the slots inside a frame. From those two counts it produces the channel index, an encoder/decoder phase flag, a serial bit-enable at half the clock rate, and two active-low strobes for the parallel sample buses.

A frame marker input realigns both counters. In normal operation the marker's falling edge is the active edge. In framer-facing operation the rising edge is active. Between markers the counters run freely, so a marker may come once per frame or once every several frames. A gapped clock is modelled by a clock-enable input: a cycle with the enable low does not exist for the block. The frame holds either 24 or 32 full-duplex channels. In interleaved operation, consecutive slots alternate between encoding and decoding one channel. Otherwise each slot is a separate half-duplex channel.

All pins are plain control and timing signals. No data stream crosses this block, so it has no valid/ready handshake and no back-pressure.

Top module: `chan_slot_timer`

## Requirements
- R1: `slot_cyc` advances by one on every clock with `clk_en` high, counting from 0 to 31 and then wrapping to 0.
- R2: With `framer_mode` low, a high-to-low change of `sync_in` clears the cycle counter and the slot counter. The change is seen between two enabled cycles. After that clock, `slot_cyc` and `chan_idx` read 0.
- R3: With `framer_mode` high, a low-to-high change of `sync_in` clears both counters, and high-to-low changes have no effect.
- R4: When no active edge occurs, both counters keep running across any number of slots.
- R5: A clock with `clk_en` low changes no counter, and `sync_in` is not sampled on it.
- R6: At the end of slot 2N-1 the slot counter wraps to 0. N is 24 when `wide_mode` is low and 32 when it is high.
- R7: With `interleave` high, `chan_idx` is the slot count shifted right by one. `dec_phase` is the slot count's bit 0, where 0 means the encoder slot and 1 means the decoder slot.
- R8: With `interleave` low, `chan_idx` equals the slot count (0 to 2N-1) and `dec_phase` stays 0.
- R9: `bit_en` is high exactly when `clk_en` is high and `slot_cyc` is even.
- R10: `pcm_stb_n` is low exactly at `slot_cyc` 28 and 29. `adpcm_stb_n` is low exactly at 30 and 31. At all other values both are high.
- R11: If the slot count is at or above 2N-1 when a slot ends, it wraps to 0. This is what happens after `wide_mode` is lowered partway through a frame.
- R12: After reset, `slot_cyc` and `chan_idx` are 0, `dec_phase` is 0 and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Active-cycle qualifier that models a gapped clock |
| sync_in | input | 1 | Frame marker |
| framer_mode | input | 1 | 1: rising marker edge is active; 0: falling edge is active |
| wide_mode | input | 1 | 1: 32 full-duplex channels; 0: 24 |
| interleave | input | 1 | 1: encoder and decoder slots alternate |
| chan_idx | output | 6 | Current channel index |
| dec_phase | output | 1 | 1 in a decoder slot |
| slot_cyc | output | 5 | Cycle position inside the slot |
| bit_en | output | 1 | Serial bit enable at half the active clock rate |
| pcm_stb_n | output | 1 | Active-low PCM bus strobe |
| adpcm_stb_n | output | 1 | Active-low ADPCM bus strobe |

## Verification
Several input patterns are applied.
- An unbroken enable with a single falling marker shows that the slot and frame counts line up with the marker and then run freely through a full 64-slot frame.
- A pseudo-random enable pattern, with markers arriving in gaps, separates counting active cycles from counting raw clocks.
- Framer-facing operation, with rising and falling marker edges in turn, shows that only the selected polarity realigns the counters.
- Narrow, non-interleaved and mid-frame narrowing runs separate the 48-slot wrap, the channel mapping and the wrap from a slot count above the limit.

// File: rtl/slot_pkg.sv
package slot_pkg;
  typedef enum logic {
    PH_ENC = 1'b0,
    PH_DEC = 1'b1
  } slot_phase_e;
endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic sync_in,
  input  logic rise_mode,
  output logic hit
);
  logic sync_q;
  logic primed;

  // the marker is sampled only on active cycles, so gaps hide it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      primed <= 1'b0;
    end else if (clk_en) begin
      sync_q <= sync_in;
      primed <= 1'b1;
    end
  end

  assign hit = clk_en && primed &&
               (rise_mode ? (sync_in && !sync_q) : (!sync_in && sync_q));

endmodule

// File: rtl/slot_counter.sv
module slot_counter #(
  parameter int CYCLES_PER_SLOT = 32,
  parameter int NARROW_CHANS    = 24,
  parameter int WIDE_CHANS      = 32,
  localparam int CYC_W  = $clog2(CYCLES_PER_SLOT),
  localparam int WORD_W = $clog2(2 * WIDE_CHANS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              clear,
  input  logic              wide_mode,
  output logic [CYC_W-1:0]  cyc,
  output logic [WORD_W-1:0] word
);
  localparam logic [CYC_W-1:0]  CYC_LAST    = CYC_W'(CYCLES_PER_SLOT - 1);
  localparam logic [WORD_W-1:0] LAST_WIDE   = WORD_W'(2 * WIDE_CHANS - 1);
  localparam logic [WORD_W-1:0] LAST_NARROW = WORD_W'(2 * NARROW_CHANS - 1);

  logic [WORD_W-1:0] word_last;
  logic              slot_end;

  assign word_last = wide_mode ? LAST_WIDE : LAST_NARROW;
  assign slot_end  = (cyc == CYC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc  <= '0;
      word <= '0;
    end else if (clk_en) begin
      if (clear) begin
        cyc  <= '0;
        word <= '0;
      end else if (slot_end) begin
        cyc  <= '0;
        word <= (word >= word_last) ? '0 : word + WORD_W'(1);
      end else begin
        cyc <= cyc + CYC_W'(1);
      end
    end
  end

  // R1: one step per active cycle
  a_r1_cyc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !clear) |=> (cyc == $past(cyc) + CYC_W'(1)));

  // R5: a gap freezes everything
  a_r5_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(cyc) && $stable(word)));

  // R2: a marker hit lands both counters on zero
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cyc == '0 && word == '0));

  // R6 and R11: the slot counter folds back at or past the frame limit
  a_r11_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !clear && slot_end && word >= word_last) |=> (word == '0));

endmodule

// File: rtl/slot_decode.sv
module slot_decode
  import slot_pkg::*;
#(
  parameter int CYCLES_PER_SLOT = 32,
  parameter int WORD_W          = 6,
  localparam int CYC_W = $clog2(CYCLES_PER_SLOT)
) (
  input  logic              clk_en,
  input  logic              interleave,
  input  logic [CYC_W-1:0]  cyc,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] chan_idx,
  output slot_phase_e       phase,
  output logic              bit_en,
  output logic [1:0]        stb_n
);
  // strobe windows close the slot: PCM bus first, ADPCM bus last
  localparam int STB_START [2] = '{CYCLES_PER_SLOT - 4, CYCLES_PER_SLOT - 2};

  always_comb begin
    if (interleave) begin
      chan_idx = word >> 1;
      phase    = word[0] ? PH_DEC : PH_ENC;
    end else begin
      chan_idx = word;
      phase    = PH_ENC;
    end
  end

  assign bit_en = clk_en && !cyc[0];

  for (genvar g = 0; g < 2; g++) begin : g_stb
    assign stb_n[g] = !((cyc == CYC_W'(STB_START[g])) ||
                        (cyc == CYC_W'(STB_START[g] + 1)));
  end

endmodule

// File: rtl/chan_slot_timer.sv
module chan_slot_timer
  import slot_pkg::*;
#(
  parameter int CYCLES_PER_SLOT = 32,
  parameter int NARROW_CHANS    = 24,
  parameter int WIDE_CHANS      = 32,
  localparam int CYC_W  = $clog2(CYCLES_PER_SLOT),
  localparam int WORD_W = $clog2(2 * WIDE_CHANS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              sync_in,
  input  logic              framer_mode,
  input  logic              wide_mode,
  input  logic              interleave,
  output logic [WORD_W-1:0] chan_idx,
  output logic              dec_phase,
  output logic [CYC_W-1:0]  slot_cyc,
  output logic              bit_en,
  output logic              pcm_stb_n,
  output logic              adpcm_stb_n
);
  logic              sync_hit;
  logic [WORD_W-1:0] word;
  logic [1:0]        stb_n;
  slot_phase_e       phase;

  sync_edge_det u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .sync_in   (sync_in),
    .rise_mode (framer_mode),
    .hit       (sync_hit)
  );

  slot_counter #(
    .CYCLES_PER_SLOT (CYCLES_PER_SLOT),
    .NARROW_CHANS    (NARROW_CHANS),
    .WIDE_CHANS      (WIDE_CHANS)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .clear     (sync_hit),
    .wide_mode (wide_mode),
    .cyc       (slot_cyc),
    .word      (word)
  );

  slot_decode #(
    .CYCLES_PER_SLOT (CYCLES_PER_SLOT),
    .WORD_W          (WORD_W)
  ) u_dec (
    .clk_en     (clk_en),
    .interleave (interleave),
    .cyc        (slot_cyc),
    .word       (word),
    .chan_idx   (chan_idx),
    .phase      (phase),
    .bit_en     (bit_en),
    .stb_n      (stb_n)
  );

  assign dec_phase   = (phase == PH_DEC);
  assign pcm_stb_n   = stb_n[0];
  assign adpcm_stb_n = stb_n[1];

  // R10: the two bus strobes never overlap
  a_r10_stb_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!pcm_stb_n && !adpcm_stb_n));

  // R10: the ADPCM strobe opens on the same edge that closes the PCM strobe
  a_r10_stb_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adpcm_stb_n) |-> $rose(pcm_stb_n));

  // R3: in framer-facing operation a falling marker never realigns
  a_r3_fall_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (framer_mode && !sync_in) |-> !sync_hit);

  // R8: non-interleaved slots never report a decoder phase
  a_r8_no_dec_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !interleave |-> !dec_phase);

endmodule

// File: tb/test_chan_slot_timer.sv
module test_chan_slot_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b0;
  logic       sync_in = 1'b0;
  logic       framer_mode = 1'b0;
  logic       wide_mode = 1'b1;
  logic       interleave = 1'b1;
  logic [5:0] chan_idx;
  logic       dec_phase;
  logic [4:0] slot_cyc;
  logic       bit_en;
  logic       pcm_stb_n;
  logic       adpcm_stb_n;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    int    cyc;
    int    chan;
    bit    ph;
    bit    be;
    bit    pcm;
    bit    adp;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  // reference state kept by the driver
  bit m_q = 0, m_primed = 0;
  int m_cyc = 0, m_word = 0;
  bit g_wide = 1, g_fr = 0, g_ilv = 1;
  string g_tag = "";

  always #4 clk = ~clk;

  chan_slot_timer i_chan_slot_timer (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sync_in(sync_in),
    .framer_mode(framer_mode), .wide_mode(wide_mode), .interleave(interleave),
    .chan_idx(chan_idx), .dec_phase(dec_phase), .slot_cyc(slot_cyc),
    .bit_en(bit_en), .pcm_stb_n(pcm_stb_n), .adpcm_stb_n(adpcm_stb_n)
  );

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic step(input bit en, input bit sy);
    exp_t e;
    bit edge_seen;
    int lim;
    @(negedge clk);
    clk_en = en; sync_in = sy;
    framer_mode = g_fr; wide_mode = g_wide; interleave = g_ilv;
    lim = g_wide ? 64 : 48;
    if (en) begin
      edge_seen = m_primed && (g_fr ? (sy && !m_q) : (!sy && m_q));
      m_q = sy; m_primed = 1;
      if (edge_seen) begin
        m_cyc = 0; m_word = 0;
      end else if (m_cyc == 31) begin
        m_cyc = 0;
        m_word = (m_word >= lim - 1) ? 0 : m_word + 1;
      end else m_cyc++;
    end
    e.cyc  = m_cyc;
    e.chan = g_ilv ? (m_word >> 1) : m_word;
    e.ph   = g_ilv ? m_word[0] : 1'b0;
    e.be   = en && (m_cyc % 2 == 0);
    e.pcm  = !(m_cyc == 28 || m_cyc == 29);
    e.adp  = !(m_cyc == 30 || m_cyc == 31);
    e.tag  = g_tag;
    exp_q.push_back(e);
  endtask

  task automatic run(input int n, input bit sy);
    for (int i = 0; i < n; i++) step(1'b1, sy);
  endtask

  // monitor: compare one expected item per clock, away from the edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() != 0) begin
        e = exp_q.pop_front();
        chk({e.tag, " R1 slot_cyc"}, slot_cyc, e.cyc);
        chk({e.tag, " R6 chan_idx"}, chan_idx, e.chan);
        chk({e.tag, " R7 dec_phase"}, dec_phase, e.ph);
        chk({e.tag, " R9 bit_en"}, bit_en, e.be);
        chk({e.tag, " R10 pcm_stb_n"}, pcm_stb_n, e.pcm);
        chk({e.tag, " R10 adpcm_stb_n"}, adpcm_stb_n, e.adp);
      end
    end
  end

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R12: state straight after reset
    chk("R12 slot_cyc", slot_cyc, 0);
    chk("R12 chan_idx", chan_idx, 0);
    chk("R12 dec_phase", dec_phase, 0);
    chk("R12 pcm_stb_n", pcm_stb_n, 1);
    chk("R12 adpcm_stb_n", adpcm_stb_n, 1);

    // R2: falling marker realigns mid-slot
    g_tag = "R2";
    run(10, 1'b1);
    run(200, 1'b0);

    // R4 and R6: free run through a whole 64-slot frame
    g_tag = "R4";
    run(70 * 32, 1'b0);

    // R6: narrow frame wraps after 48 slots
    g_tag = "R6";
    g_wide = 0;
    run(3, 1'b1);
    run(48 * 32 + 64, 1'b0);

    // R5: gapped clock, markers sometimes fall inside gaps
    g_tag = "R5";
    g_wide = 1;
    for (int i = 0; i < 1500; i++)
      step(($urandom % 3) != 0, (i % 211) < 6);

    // R3: framer-facing polarity, rise realigns, fall ignored
    g_tag = "R3";
    g_fr = 1;
    run(5, 1'b0);
    run(50, 1'b1);
    run(80, 1'b0);
    g_fr = 0;

    // R8: half-duplex channel mapping
    g_tag = "R8";
    g_ilv = 0;
    run(3, 1'b1);
    run(200, 1'b0);

    // R11: narrowing the frame while the slot count is past the new limit
    g_tag = "R11";
    g_ilv = 1;
    run(3, 1'b1);
    run(55 * 32, 1'b0);
    g_wide = 0;
    run(64, 1'b0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule